// File: doc/BRIEF.md
# Precision Time Protocol System Time Counter

This block keeps the free-running 64-bit time base of a network timestamping unit. The time is held in a wider accumulator whose lowest bits are a fraction of one count. Each tick adds a programmable increment to that accumulator. A small period code in the increment word decides how many clock cycles make up one tick. Software tunes the frequency only by writing a new increment word. The accumulated value, fraction included, is never disturbed by that write. The whole 64-bit count is driven continuously to the timestamp latches and the target-time comparators.

Software sees three 32-bit registers on a simple write and read port: the low time half, the high time half, and the increment word. A write to the high half is held in a staging register. The following write to the low half loads both halves into the counter in a single cycle. Reads are not latched. A reader that needs a consistent pair therefore reads high, then low, then high again, and repeats the low read if the two high values differ.

A build parameter selects one of two increment formats. The standard format has a 24-bit increment and a 2-bit period code. The alternate format has a 27-bit increment, has no period code, and ticks every cycle.

Top module: `systime_core`

## Requirements
- R1: While reset is held and in the first cycle after it, the time output is zero. After reset, the increment word reads back as the reset parameter (default 0x0280_0000) masked to the format's stored bits.
- R2: In standard format the increment word stores bits 25:0 only. Bits 23:0 are the increment and bits 25:24 are the period code. Bits 31:26 are dropped and read back as zero.
- R3: In standard format a period code p of 1, 2 or 3 adds the increment once every p clock cycles. Code 0 stops the counter.
- R4: The increment is added to an accumulator that holds FRAC_W bits (default 8) below the 64-bit time, so one increment unit is 2^-FRAC_W of a count. Carries from the fraction reach the visible time.
- R5: Writing the increment word changes the amount added from the next tick on and leaves the accumulated time and fraction unchanged. It also restarts the tick phase, so the first tick comes p cycles after the write.
- R6: Register addresses are 0 for time low, 1 for time high and 2 for the increment word. A high write only stages its value. A low write loads {staged high, written low} into the time and clears the fraction in the same cycle. The load takes priority over a tick in that cycle.
- R7: Writing zero to the high register and then to the low register sets the time to zero.
- R8: A read strobe returns data and a valid flag one cycle later. The data is the live value at the strobe edge. Address 3 reads as zero, and writes to address 3 have no effect.
- R9: The time wraps modulo 2^64 without any flag.
- R10: With ALT_MODE set, the increment word stores bits 26:0 as the increment, has no period code, and adds the increment on every clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 time low, 1 time high, 2 increment, 3 spare) |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | 2 | Read address, same encoding as wr_addr |
| rd_valid | output | 1 | Read data valid, one cycle after rd_en |
| rd_data | output | 32 | Read data |
| time_o | output | 64 | Live system time to latches and comparators |

## Verification
The counter is run under every period code, including the stopped code 0, and with increments that have a half-count fraction. This separates a tick-rate fault from a fraction-carry fault. Two increment writes in a row, with the fraction left at one half, show whether a rewrite clears the accumulated fraction. Stop–load–read sequences check the staged high write against the loading low write, and the zero load. A load just below 2^64 followed by ticks that cross the boundary checks the wrap. A standard-format and an alternate-format instance receive the same stimulus. This shows how each format masks the all-ones word and how the alternate format keeps counting while the standard one is stopped.

// File: rtl/systime_pkg.sv
package systime_pkg;

  // register selector carried on wr_addr / rd_addr
  typedef enum logic [1:0] {
    SEL_TIME_LO = 2'd0,
    SEL_TIME_HI = 2'd1,
    SEL_INCR    = 2'd2,
    SEL_SPARE   = 2'd3
  } sel_e;

  // width of the period code in the standard increment word
  localparam int PCODE_W = 2;

endpackage

// File: rtl/systime_incr.sv
// Increment word storage and decode into step value and tick period.
module systime_incr
  import systime_pkg::*;
#(
  parameter int ALT_MODE  = 0,
  parameter int STD_INC_W = 24,
  parameter int KEEP_BITS = 26,
  parameter int INC_W     = 24,
  parameter logic [KEEP_BITS-1:0] RESET_WORD = '0
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_stb,
  input  logic [KEEP_BITS-1:0] wr_word,
  output logic [KEEP_BITS-1:0] word_o,
  output logic [INC_W-1:0]     inc_o,
  output logic [PCODE_W-1:0]   period_o
);

  logic [KEEP_BITS-1:0] word_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_q <= RESET_WORD;
    end else if (wr_stb) begin
      word_q <= wr_word;
    end
  end

  assign word_o = word_q;

  generate
    if (ALT_MODE != 0) begin : g_alt
      // whole stored word is the step, one tick per cycle
      assign inc_o    = word_q;
      assign period_o = PCODE_W'(1);
    end else begin : g_std
      assign inc_o    = word_q[STD_INC_W-1:0];
      assign period_o = word_q[STD_INC_W +: PCODE_W];
    end
  endgenerate

endmodule

// File: rtl/systime_pacer.sv
// Divides the clock into ticks according to the period code.
module systime_pacer #(
  parameter int PCODE_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               restart,
  input  logic [PCODE_W-1:0] period,
  output logic               tick
);

  logic [PCODE_W-1:0] phase_q;
  logic [PCODE_W-1:0] last_phase;
  logic               running;

  assign last_phase = period - PCODE_W'(1);
  assign running    = (period != '0);
  assign tick       = running && (phase_q == last_phase);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      phase_q <= '0;
    end else if (tick) begin
      phase_q <= '0;
    end else if (running) begin
      phase_q <= phase_q + PCODE_W'(1);
    end
  end

endmodule

// File: rtl/systime_accum.sv
// Fractional accumulator with staged high half and atomic load.
module systime_accum #(
  parameter int DATA_W = 32,
  parameter int FRAC_W = 8,
  parameter int INC_W  = 24
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                hi_wr,
  input  logic                lo_wr,
  input  logic [DATA_W-1:0]   data_i,
  input  logic                tick,
  input  logic [INC_W-1:0]    inc,
  output logic [2*DATA_W-1:0] time_o
);

  localparam int TIME_W = 2 * DATA_W;
  localparam int ACC_W  = TIME_W + FRAC_W;

  logic [ACC_W-1:0]  acc_q;
  logic [DATA_W-1:0] hi_stage_q;
  logic [ACC_W-1:0]  step;

  assign step   = {{(ACC_W-INC_W){1'b0}}, inc};
  assign time_o = acc_q[FRAC_W +: TIME_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      hi_stage_q <= '0;
    end else if (hi_wr) begin
      hi_stage_q <= data_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= '0;
    end else if (lo_wr) begin
      acc_q <= {hi_stage_q, data_i, {FRAC_W{1'b0}}};
    end else if (tick) begin
      acc_q <= acc_q + step;   // wraps modulo 2^ACC_W
    end
  end

endmodule

// File: rtl/systime_rdport.sv
// Registered read multiplexer.
module systime_rdport
  import systime_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEEP_BITS = 26
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 rd_en,
  input  logic [1:0]           rd_addr,
  input  logic [2*DATA_W-1:0]  time_i,
  input  logic [KEEP_BITS-1:0] word_i,
  output logic                 rd_valid,
  output logic [DATA_W-1:0]    rd_data
);

  logic [DATA_W-1:0] mux_val;

  always_comb begin
    case (sel_e'(rd_addr))
      SEL_TIME_LO: mux_val = time_i[DATA_W-1:0];
      SEL_TIME_HI: mux_val = time_i[2*DATA_W-1:DATA_W];
      SEL_INCR:    mux_val = DATA_W'(word_i);
      default:     mux_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) begin
        rd_data <= mux_val;
      end
    end
  end

endmodule

// File: rtl/systime_core.sv
// System time counter top: register port, increment decode, pacer, accumulator.
module systime_core
  import systime_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int FRAC_W    = 8,
  parameter int STD_INC_W = 24,
  parameter int ALT_INC_W = 27,
  parameter int ALT_MODE  = 0,
  parameter logic [31:0] RESET_INC = 32'h0280_0000
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [1:0]          wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                rd_en,
  input  logic [1:0]          rd_addr,
  output logic                rd_valid,
  output logic [DATA_W-1:0]   rd_data,
  output logic [2*DATA_W-1:0] time_o
);

  localparam int KEEP_BITS = (ALT_MODE != 0) ? ALT_INC_W : STD_INC_W + PCODE_W;
  localparam int INC_W     = (ALT_MODE != 0) ? ALT_INC_W : STD_INC_W;

  logic                 hi_wr;
  logic                 lo_load;
  logic                 inc_wr;
  logic [KEEP_BITS-1:0] inc_word;
  logic [INC_W-1:0]     inc_val;
  logic [PCODE_W-1:0]   tick_period;
  logic                 tick;

  assign hi_wr   = wr_en && (wr_addr == SEL_TIME_HI);
  assign lo_load = wr_en && (wr_addr == SEL_TIME_LO);
  assign inc_wr  = wr_en && (wr_addr == SEL_INCR);

  systime_incr #(
    .ALT_MODE  (ALT_MODE),
    .STD_INC_W (STD_INC_W),
    .KEEP_BITS (KEEP_BITS),
    .INC_W     (INC_W),
    .RESET_WORD(RESET_INC[KEEP_BITS-1:0])
  ) u_incr (
    .clk     (clk),
    .rst     (rst),
    .wr_stb  (inc_wr),
    .wr_word (wr_data[KEEP_BITS-1:0]),
    .word_o  (inc_word),
    .inc_o   (inc_val),
    .period_o(tick_period)
  );

  systime_pacer #(
    .PCODE_W(PCODE_W)
  ) u_pacer (
    .clk    (clk),
    .rst    (rst),
    .restart(inc_wr),
    .period (tick_period),
    .tick   (tick)
  );

  systime_accum #(
    .DATA_W(DATA_W),
    .FRAC_W(FRAC_W),
    .INC_W (INC_W)
  ) u_accum (
    .clk   (clk),
    .rst   (rst),
    .hi_wr (hi_wr),
    .lo_wr (lo_load),
    .data_i(wr_data),
    .tick  (tick),
    .inc   (inc_val),
    .time_o(time_o)
  );

  systime_rdport #(
    .DATA_W   (DATA_W),
    .KEEP_BITS(KEEP_BITS)
  ) u_rdport (
    .clk     (clk),
    .rst     (rst),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .time_i  (time_o),
    .word_i  (inc_word),
    .rd_valid(rd_valid),
    .rd_data (rd_data)
  );

endmodule

// File: rtl/systime_core_chk.sv
// Property checker attached to systime_core.
module systime_core_chk
  import systime_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int KEEP_BITS = 26
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [1:0]          wr_addr,
  input logic [DATA_W-1:0]   wr_data,
  input logic                rd_en,
  input logic [1:0]          rd_addr,
  input logic                rd_valid,
  input logic [DATA_W-1:0]   rd_data,
  input logic [2*DATA_W-1:0] time_o,
  input logic                tick,
  input logic [PCODE_W-1:0]  tick_period
);

  localparam logic [DATA_W-1:0] KEEP_MASK = DATA_W'((64'd1 << KEEP_BITS) - 64'd1);

  logic rst_seen;
  logic lo_wr;
  logic incr_wr;

  assign lo_wr   = wr_en && (wr_addr == SEL_TIME_LO);
  assign incr_wr = wr_en && (wr_addr == SEL_INCR);

  always_ff @(posedge clk) rst_seen <= rst;

  always @(posedge clk) begin
    if (rst_seen) begin
      AST_RST_CLEARS: assert (time_o == '0) else $error("time not cleared by reset"); // R1
    end
  end

  AST_LOAD_LOW: assert property (@(posedge clk) disable iff (rst)
    lo_wr |=> time_o[DATA_W-1:0] == $past(wr_data)) else $error("low load mismatch"); // R6

  AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (rst)
    (!tick && !lo_wr) |=> $stable(time_o)) else $error("time moved without tick"); // R3

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick && tick_period >= PCODE_W'(2) && !incr_wr) |=> !tick) else $error("ticks too close"); // R3

  AST_RD_VALID: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_valid) else $error("read not answered"); // R8

  AST_INC_UNUSED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd_en && rd_addr == SEL_INCR) |=> (rd_data & ~KEEP_MASK) == '0) else $error("unused bits set"); // R2

endmodule

bind systime_core systime_core_chk #(
  .DATA_W   (DATA_W),
  .KEEP_BITS(KEEP_BITS)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .wr_en      (wr_en),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .rd_en      (rd_en),
  .rd_addr    (rd_addr),
  .rd_valid   (rd_valid),
  .rd_data    (rd_data),
  .time_o     (time_o),
  .tick       (tick),
  .tick_period(tick_period)
);

// File: tb/test_systime_core.sv
module test_systime_core;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [1:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [1:0]  rd_addr = '0;
  logic        rv  [2];
  logic [31:0] rdd [2];
  logic [63:0] tm  [2];

  systime_core #(.ALT_MODE(0)) i_systime_core (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rv[0]), .rd_data(rdd[0]), .time_o(tm[0]));

  systime_core #(.ALT_MODE(1)) i_systime_core_alt (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_valid(rv[1]), .rd_data(rdd[1]), .time_o(tm[1]));

  // reference state, index 0 standard, 1 alternate
  logic [71:0] m_acc  [2];
  logic [31:0] m_hi   [2];
  logic [31:0] m_word [2];
  logic [1:0]  m_ph   [2];

  typedef struct {
    logic [31:0] e0;
    logic [31:0] e1;
    string       req;
  } exp_t;
  exp_t exp_q[$];

  int    n_chk = 0;
  int    n_fail = 0;
  bit    mon_on = 1'b0;
  bit    exp_rv = 1'b0;
  bit    finished = 1'b0;
  string cur_tag = "R1";

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] keep(input int k);
    return (k != 0) ? 32'h07FF_FFFF : 32'h03FF_FFFF;
  endfunction

  function automatic logic [1:0] m_period(input int k);
    return (k != 0) ? 2'd1 : m_word[0][25:24];
  endfunction

  function automatic logic [71:0] m_inc(input int k);
    return (k != 0) ? {45'd0, m_word[1][26:0]} : {48'd0, m_word[0][23:0]};
  endfunction

  function automatic logic [31:0] m_read(input int k, input logic [1:0] a);
    case (a)
      2'd0:    return m_acc[k][39:8];
      2'd1:    return m_acc[k][71:40];
      2'd2:    return m_word[k];
      default: return 32'h0;
    endcase
  endfunction

  task automatic model_reset();
    for (int k = 0; k < 2; k++) begin
      m_acc[k]  = '0;
      m_hi[k]   = '0;
      m_word[k] = 32'h0280_0000 & keep(k);
      m_ph[k]   = '0;
    end
  endtask

  // driver: called at a falling edge, returns at the next falling edge
  task automatic step(input bit we, input logic [1:0] wa, input logic [31:0] wd,
                      input bit re, input logic [1:0] ra, input string tag);
    exp_t it;
    cur_tag = tag;
    wr_en = we; wr_addr = wa; wr_data = wd;
    rd_en = re; rd_addr = ra;
    if (re) begin
      it.e0 = m_read(0, ra);
      it.e1 = m_read(1, ra);
      it.req = tag;
      exp_q.push_back(it);
    end
    @(posedge clk);
    for (int k = 0; k < 2; k++) begin
      automatic logic [1:0]  p = m_period(k);
      automatic bit          t = (p != 2'd0) && (m_ph[k] == p - 2'd1);
      automatic logic [71:0] iv = m_inc(k);
      if (we && wa == 2'd1) m_hi[k] = wd;
      if (we && wa == 2'd0) m_acc[k] = {m_hi[k], wd, 8'h00};
      else if (t) m_acc[k] = m_acc[k] + iv;
      if (we && wa == 2'd2) begin
        m_word[k] = wd & keep(k);
        m_ph[k]   = 2'd0;
      end else if (p != 2'd0) begin
        m_ph[k] = t ? 2'd0 : m_ph[k] + 2'd1;
      end
    end
    exp_rv = re;
    @(negedge clk);
    wr_en = 1'b0;
    rd_en = 1'b0;
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 2'd0, 32'h0, 1'b0, 2'd0, tag);
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d, input string tag);
    step(1'b1, a, d, 1'b0, 2'd0, tag);
  endtask

  task automatic rd(input logic [1:0] a, input string tag);
    step(1'b0, 2'd0, 32'h0, 1'b1, a, tag);
  endtask

  // monitor: compares live time, valid flag and popped read results
  always @(negedge clk) begin
    if (mon_on && !rst) begin
      for (int k = 0; k < 2; k++) begin
        chk(tm[k] == m_acc[k][71:8], (k != 0) ? {"R10/R4/", cur_tag} : {"R4/", cur_tag},
            tm[k], m_acc[k][71:8]);
        chk(rv[k] == exp_rv, "R8 valid", 64'(rv[k]), 64'(exp_rv));
      end
      if (rv[0] && exp_q.size() > 0) begin
        automatic exp_t it = exp_q.pop_front();
        chk(rdd[0] == it.e0, it.req, 64'(rdd[0]), 64'(it.e0));
        chk(rdd[1] == it.e1, {"R10/", it.req}, 64'(rdd[1]), 64'(it.e1));
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 64'd0, 64'd1);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1: time cleared during reset
    chk(tm[0] == 64'd0, "R1", tm[0], 64'd0);
    chk(tm[1] == 64'd0, "R1", tm[1], 64'd0);
    rst = 1'b0;
    mon_on = 1'b1;

    // R1: reset increment word and early time
    rd(2'd2, "R1");
    rd(2'd0, "R1");
    rd(2'd1, "R1");
    idle(5, "R3");

    // R2: upper bits dropped, both formats
    wr(2'd2, 32'hFFFF_FFFF, "R2");
    rd(2'd2, "R2");
    idle(4, "R3");

    // R3: code 0 stops standard counter (alternate keeps running)
    wr(2'd2, 32'h0000_0100, "R3");
    idle(3, "R3");
    rd(2'd0, "R3");

    // R6: staged high has no effect until low write
    wr(2'd1, 32'h1234_5678, "R6");
    idle(2, "R6");
    rd(2'd1, "R6");
    wr(2'd0, 32'h9ABC_DEF0, "R6");
    rd(2'd1, "R6");
    rd(2'd0, "R6");

    // R4: 1.5 counts per tick, fraction carries
    wr(2'd2, 32'h0100_0180, "R4");
    idle(6, "R4");
    rd(2'd0, "R4");

    // R3: period codes 2 and 3
    wr(2'd2, 32'h0200_0180, "R3");
    idle(7, "R3");
    rd(2'd0, "R3");
    wr(2'd2, 32'h0300_0180, "R3");
    idle(9, "R3");
    rd(2'd0, "R3");

    // R6: low load while ticking every cycle, load wins
    wr(2'd2, 32'h0100_0100, "R6");
    wr(2'd0, 32'h0000_0040, "R6");
    rd(2'd0, "R6");

    // R5: rewrite increment with half-count fraction pending
    wr(2'd2, 32'h0100_0080, "R5");
    idle(1, "R5");
    wr(2'd2, 32'h0100_0100, "R5");
    idle(3, "R5");
    rd(2'd0, "R5");

    // R7: stop both, zero load
    wr(2'd2, 32'h0000_0000, "R7");
    wr(2'd1, 32'h0000_0000, "R7");
    wr(2'd0, 32'h0000_0000, "R7");
    rd(2'd0, "R7");
    rd(2'd1, "R7");
    chk(tm[0] == 64'd0, "R7", tm[0], 64'd0);
    chk(tm[1] == 64'd0, "R7", tm[1], 64'd0);

    // R9: wrap past 2^64
    wr(2'd1, 32'hFFFF_FFFF, "R9");
    wr(2'd0, 32'hFFFF_FFFE, "R9");
    rd(2'd1, "R9");
    wr(2'd2, 32'h0100_0200, "R9");
    idle(3, "R9");
    rd(2'd0, "R9");
    rd(2'd1, "R9");

    // R8: spare address ignored on write, reads zero
    wr(2'd3, 32'hFFFF_FFFF, "R8");
    rd(2'd3, "R8");
    rd(2'd2, "R8");
    rd(2'd1, "R8");
    rd(2'd0, "R8");

    // R10: alternate runs every cycle with a wide step
    wr(2'd2, 32'h0512_3456, "R10");
    idle(4, "R10");
    rd(2'd0, "R10");
    rd(2'd2, "R10");

    idle(3, "R8");
    chk(exp_q.size() == 0, "R8 pending", 64'(exp_q.size()), 64'd0);
    finish_run();
  end

endmodule